// File: doc/BRIEF.md
# Tile Shape Configuration Unit

This unit holds the shape of a bank of matrix tile registers. Software or a load engine writes a 64-byte configuration image into a staging buffer through a word-wide write port, and then issues a commit. The unit checks the staged image. A valid image with a non-zero selector becomes the active configuration. The per-tile row count and bytes-per-row of the active configuration are presented to the matrix datapath. An invalid image raises a one-cycle fault and leaves the active configuration as it was.

A selector of zero in byte 0, or a release command, returns the unit to its init state. In that state every shape field is zero and the unit is unconfigured. A one-cycle clear strobe is also sent to the tile data storage. The active configuration can be read back as a 64-byte image, one word at a time. While the unit is unconfigured the read-back is all zero.

Top module: `tile_cfg_unit`

## Requirements
- R1: After reset, configured, fault and clear_tiles are 0, all tile_rows and tile_colbytes fields are 0, and every read-back word is 0.
- R2: A write with wr_en stores wr_data into staging word wr_addr, little-endian, so that image byte i is bits [8*(i%4)+7 : 8*(i%4)] of word i/4. One cycle after a commit of a valid image whose byte 0 is 1, configured is 1. Tile t's bytes-per-row is then the 16-bit little-endian value at bytes 16+2t and 17+2t, on tile_colbytes[16t+15:16t]. Its row count is byte 48+t, on tile_rows[8t+7:8t].
- R3: The read-back image holds the active selector in byte 0, the active bytes-per-row and row-count fields at the positions given in R2, and zero in every other byte. rd_data is combinational from rd_addr.
- R4: A commit whose byte 0 is 0 is accepted whatever the other bytes hold. One cycle later configured is 0, every shape field is 0, fault is 0, and clear_tiles is high for exactly one cycle.
- R5: A commit whose byte 0 is greater than 1 raises fault for exactly one cycle, one cycle later. configured, tile_rows, tile_colbytes and the read-back stay unchanged.
- R6: A row count above 16 or a bytes-per-row above 64 makes the image invalid, with the effect of R5. Exactly 16 rows and exactly 64 bytes-per-row are valid.
- R7: With byte 0 equal to 1, a non-zero value in any byte outside 0, 16..31 and 48..55 makes the image invalid, with the effect of R5.
- R8: release_req has the effect of R4 one cycle later, whatever the staged image holds. When release_req and commit are asserted together, release wins and the commit is dropped.
- R9: After the init state has been entered through R4 or R8, every read-back word is 0.
- R10: A commit evaluates the staging contents from before any write in the same cycle. The staging buffer keeps its contents after a commit, so the same image can be committed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one staging word |
| wr_addr | input | 4 | Staging word index |
| wr_data | input | 32 | Staging word data, little-endian bytes |
| commit | input | 1 | Check the staged image and apply it |
| release_req | input | 1 | Return to the init state |
| rd_addr | input | 4 | Read-back word index |
| rd_data | output | 32 | Read-back word of the active image |
| configured | output | 1 | A non-zero-selector configuration is active |
| fault | output | 1 | One-cycle pulse: the last commit was rejected |
| clear_tiles | output | 1 | One-cycle pulse: clear all tile data |
| tile_rows | output | 64 | Row count per tile, 8 bits each |
| tile_colbytes | output | 128 | Bytes-per-row per tile, 16 bits each |

## Verification
Directed images isolate each rejection cause on its own: a bad selector, a row count one above the limit, a bytes-per-row one above the limit, and stray reserved bytes at both ends of the image. Images exactly at the limits show that the bounds are inclusive. Selector-zero images carrying junk, and a release issued together with a commit, show that the init path overrides checking and the commit. A write issued in the commit cycle shows which staging snapshot is checked. Randomly generated images then mix all causes, including several at once, so that a wrong combination of the checks, or a fault that disturbs the held shape, shows up against the bench's own model.

// File: rtl/tcfg_pkg.sv
// Shared constants and layout helpers for the tile shape configuration unit.
// Assumes a fixed 64-byte image with eight tile slots.
package tcfg_pkg;
    localparam int IMG_BYTES = 64;
    localparam int IMG_BITS  = IMG_BYTES * 8;
    localparam int SLOTS     = 8;
    localparam int BPR_BASE  = 16;
    localparam int ROWS_BASE = 48;

    // True when byte idx belongs to a field of one of the first ntiles slots.
    function automatic logic is_field(input int idx, input int ntiles);
        return (idx == 0) ||
               (idx >= BPR_BASE  && idx < BPR_BASE + 2 * ntiles) ||
               (idx >= ROWS_BASE && idx < ROWS_BASE + ntiles);
    endfunction
endpackage

// File: rtl/tcfg_stage.sv
// Staging buffer for the 64-byte configuration image.
// Word-addressed writes with little-endian byte placement; cleared by reset.
module tcfg_stage #(
    parameter int WORD_BYTES = 4,
    localparam int WORDS = tcfg_pkg::IMG_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [WORD_BYTES*8-1:0]       wr_data,
    output logic [tcfg_pkg::IMG_BITS-1:0] img
);
    localparam int WB = WORD_BYTES * 8;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Capture one staging word when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                img[w*WB +: WB] <= '0;
            else if (wr_en && wr_addr == AW'(w))
                img[w*WB +: WB] <= wr_data;
        end
    end
endmodule

// File: rtl/tcfg_check.sv
// Combinational validator and field extractor for a staged image.
// Assumes selector 0 means init (no other checks) and 1 is the only shape selector.
module tcfg_check #(
    parameter int NTILES   = 8,
    parameter int MAX_ROWS = 16,
    parameter int MAX_COLB = 64
) (
    input  logic [tcfg_pkg::IMG_BITS-1:0] img,
    output logic                          img_ok,
    output logic                          img_init,
    output logic [7:0]                    sel,
    output logic [NTILES*8-1:0]           rows,
    output logic [NTILES*16-1:0]          colb
);
    import tcfg_pkg::*;
    localparam logic [7:0]  ROW_LIM = MAX_ROWS[7:0];
    localparam logic [15:0] COL_LIM = MAX_COLB[15:0];

    logic bad;

    // Extract fields and flag any bound or reserved-byte violation.
    always_comb begin
        sel = img[7:0];
        bad = 1'b0;
        for (int t = 0; t < NTILES; t++) begin
            rows[t*8 +: 8]   = img[8*(ROWS_BASE + t) +: 8];
            colb[t*16 +: 16] = img[8*(BPR_BASE + 2*t) +: 16];
            if (rows[t*8 +: 8] > ROW_LIM)   bad = 1'b1;
            if (colb[t*16 +: 16] > COL_LIM) bad = 1'b1;
        end
        for (int i = 0; i < IMG_BYTES; i++)
            if (!is_field(i, NTILES) && img[8*i +: 8] != 8'd0) bad = 1'b1;
        img_init = (sel == 8'd0);
        img_ok   = img_init || (sel == 8'd1 && !bad);
    end
endmodule

// File: rtl/tcfg_regs.sv
// Active configuration registers, init/fault sequencing and read-back image.
// Release has priority over commit; pulses last one cycle.
module tcfg_regs #(
    parameter int NTILES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic                          release_req,
    input  logic                          img_ok,
    input  logic                          img_init,
    input  logic [7:0]                    sel,
    input  logic [NTILES*8-1:0]           rows,
    input  logic [NTILES*16-1:0]          colb,
    output logic                          configured,
    output logic                          fault,
    output logic                          clear_tiles,
    output logic [NTILES*8-1:0]           rows_q,
    output logic [NTILES*16-1:0]          colb_q,
    output logic [tcfg_pkg::IMG_BITS-1:0] rb_img
);
    import tcfg_pkg::*;
    logic [7:0] sel_q;

    // Apply release, init, fault or load on each command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            configured  <= 1'b0;
            fault       <= 1'b0;
            clear_tiles <= 1'b0;
            sel_q       <= '0;
            rows_q      <= '0;
            colb_q      <= '0;
        end else begin
            fault       <= 1'b0;
            clear_tiles <= 1'b0;
            if (release_req || (commit && img_ok && img_init)) begin
                configured  <= 1'b0;
                clear_tiles <= 1'b1;
                sel_q       <= '0;
                rows_q      <= '0;
                colb_q      <= '0;
            end else if (commit && !img_ok) begin
                fault <= 1'b1;
            end else if (commit) begin
                configured <= 1'b1;
                sel_q      <= sel;
                rows_q     <= rows;
                colb_q     <= colb;
            end
        end
    end

    // Rebuild the 64-byte image from the active fields.
    always_comb begin
        rb_img = '0;
        rb_img[7:0] = sel_q;
        for (int t = 0; t < NTILES; t++) begin
            rb_img[8*(BPR_BASE + 2*t) +: 16] = colb_q[t*16 +: 16];
            rb_img[8*(ROWS_BASE + t) +: 8]   = rows_q[t*8 +: 8];
        end
    end
endmodule

// File: rtl/tile_cfg_unit.sv
// Top of the tile shape configuration unit: staging, validation, active state
// and word-wide read-back. NTILES must not exceed the eight layout slots.
module tile_cfg_unit #(
    parameter int NTILES     = 8,
    parameter int WORD_BYTES = 4,
    parameter int MAX_ROWS   = 16,
    parameter int MAX_COLB   = 64,
    localparam int WORDS = tcfg_pkg::IMG_BYTES / WORD_BYTES,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [WORD_BYTES*8-1:0] wr_data,
    input  logic                    commit,
    input  logic                    release_req,
    input  logic [AW-1:0]           rd_addr,
    output logic [WORD_BYTES*8-1:0] rd_data,
    output logic                    configured,
    output logic                    fault,
    output logic                    clear_tiles,
    output logic [NTILES*8-1:0]     tile_rows,
    output logic [NTILES*16-1:0]    tile_colbytes
);
    localparam int WB = WORD_BYTES * 8;

    logic [tcfg_pkg::IMG_BITS-1:0] stage_img;
    logic [tcfg_pkg::IMG_BITS-1:0] rb_img;
    logic                          img_ok, img_init;
    logic [7:0]                    sel;
    logic [NTILES*8-1:0]           rows;
    logic [NTILES*16-1:0]          colb;
    logic [WB-1:0]                 rb_words [WORDS];

    tcfg_stage #(.WORD_BYTES(WORD_BYTES)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .img(stage_img)
    );

    tcfg_check #(.NTILES(NTILES), .MAX_ROWS(MAX_ROWS), .MAX_COLB(MAX_COLB)) u_check (
        .img(stage_img), .img_ok(img_ok), .img_init(img_init),
        .sel(sel), .rows(rows), .colb(colb)
    );

    tcfg_regs #(.NTILES(NTILES)) u_regs (
        .clk(clk), .rst_n(rst_n), .commit(commit), .release_req(release_req),
        .img_ok(img_ok), .img_init(img_init), .sel(sel), .rows(rows), .colb(colb),
        .configured(configured), .fault(fault), .clear_tiles(clear_tiles),
        .rows_q(tile_rows), .colb_q(tile_colbytes), .rb_img(rb_img)
    );

    for (genvar w = 0; w < WORDS; w++) begin : g_rb
        assign rb_words[w] = rb_img[w*WB +: WB];
    end

    assign rd_data = rb_words[rd_addr];
endmodule

// File: rtl/tcfg_chk.sv
// Temporal checks on the tile shape configuration unit, bound to its top.
module tcfg_chk #(
    parameter int NTILES   = 8,
    parameter int MAX_ROWS = 16,
    parameter int MAX_COLB = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 commit,
    input logic                 release_req,
    input logic                 configured,
    input logic                 fault,
    input logic                 clear_tiles,
    input logic [NTILES*8-1:0]  tile_rows,
    input logic [NTILES*16-1:0] tile_colbytes
);
    function automatic logic in_bounds(input logic [NTILES*8-1:0] r,
                                       input logic [NTILES*16-1:0] c);
        logic ok;
        ok = 1'b1;
        for (int t = 0; t < NTILES; t++) begin
            if (32'(r[t*8 +: 8]) > MAX_ROWS)   ok = 1'b0;
            if (32'(c[t*16 +: 16]) > MAX_COLB) ok = 1'b0;
        end
        return ok;
    endfunction

    // R5
    fault_holds_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(tile_rows) && $stable(tile_colbytes) && $stable(configured)));

    // R5
    fault_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($past(commit) && !$past(release_req)));

    // R8
    release_inits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_req |=> (!configured && clear_tiles && !fault));

    // R4
    clear_is_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_tiles |-> (!configured && tile_rows == '0 && tile_colbytes == '0 && !fault));

    // R9
    unconfigured_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !configured |-> (tile_rows == '0 && tile_colbytes == '0));

    // R2
    config_needs_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(configured) |-> ($past(commit) && !$past(release_req)));

    // R6
    shape_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_bounds(tile_rows, tile_colbytes));
endmodule

bind tile_cfg_unit tcfg_chk #(.NTILES(NTILES), .MAX_ROWS(MAX_ROWS), .MAX_COLB(MAX_COLB)) u_tcfg_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .release_req(release_req),
    .configured(configured), .fault(fault), .clear_tiles(clear_tiles),
    .tile_rows(tile_rows), .tile_colbytes(tile_colbytes)
);

// File: tb/tb_tile_cfg_unit.sv
// Self-checking bench: directed corner cases plus seeded random images.
module tb_tile_cfg_unit;
    localparam int NT = 8, WORDS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        commit = 1'b0;
    logic        release_req = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        configured, fault, clear_tiles;
    logic [63:0] tile_rows;
    logic [127:0] tile_colbytes;

    int checks = 0, failures = 0;

    // Bench model: staged image and expected active state.
    logic [7:0]  img [64];
    logic [7:0]  m_sel;
    logic [7:0]  m_rows [NT];
    logic [15:0] m_colb [NT];
    logic        m_cfg, m_fault, m_clr;

    always #2 clk = ~clk;

    tile_cfg_unit dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .release_req(release_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .configured(configured), .fault(fault), .clear_tiles(clear_tiles),
        .tile_rows(tile_rows), .tile_colbytes(tile_colbytes)
    );

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic field_byte(input int i);
        return i == 0 || (i >= 16 && i < 32) || (i >= 48 && i < 56);
    endfunction

    function automatic logic img_valid();
        if (img[0] == 8'd0) return 1'b1;
        if (img[0] != 8'd1) return 1'b0;
        for (int i = 0; i < 64; i++) if (!field_byte(i) && img[i] != 0) return 1'b0;
        for (int t = 0; t < NT; t++) begin
            if (img[48+t] > 16) return 1'b0;
            if ({img[17+2*t], img[16+2*t]} > 16'd64) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [7:0] rb_byte(input int i);
        if (i == 0) return m_sel;
        if (i >= 16 && i < 32) return (i % 2 == 0) ? m_colb[(i-16)/2][7:0] : m_colb[(i-16)/2][15:8];
        if (i >= 48 && i < 56) return m_rows[i-48];
        return 8'd0;
    endfunction

    task automatic model_init();
        m_sel = 0; m_cfg = 0;
        for (int t = 0; t < NT; t++) begin m_rows[t] = 0; m_colb[t] = 0; end
    endtask

    task automatic model_commit(input logic rel);
        m_fault = 0; m_clr = 0;
        if (rel || (img[0] == 0)) begin model_init(); m_clr = 1; end
        else if (!img_valid()) m_fault = 1;
        else begin
            m_sel = img[0]; m_cfg = 1;
            for (int t = 0; t < NT; t++) begin
                m_rows[t] = img[48+t];
                m_colb[t] = {img[17+2*t], img[16+2*t]};
            end
        end
    endtask

    task automatic write_image();
        for (int w = 0; w < WORDS; w++) begin
            @(negedge clk);
            wr_en = 1; wr_addr = 4'(w);
            wr_data = {img[4*w+3], img[4*w+2], img[4*w+1], img[4*w]};
        end
        @(negedge clk); wr_en = 0;
    endtask

    task automatic check_state(input string tag);
        logic [63:0] er; logic [127:0] ec;
        for (int t = 0; t < NT; t++) begin er[t*8 +: 8] = m_rows[t]; ec[t*16 +: 16] = m_colb[t]; end
        chk({tag, " configured"}, 128'(configured), 128'(m_cfg));
        chk({tag, " fault"}, 128'(fault), 128'(m_fault));
        chk({tag, " clear_tiles"}, 128'(clear_tiles), 128'(m_clr));
        chk({tag, " tile_rows"}, 128'(tile_rows), 128'(er));
        chk({tag, " tile_colbytes"}, tile_colbytes, ec);
    endtask

    task automatic check_readback(input string tag);
        for (int w = 0; w < WORDS; w++) begin
            rd_addr = 4'(w); #0.5;
            chk({tag, " readback"}, 128'(rd_data),
                128'({rb_byte(4*w+3), rb_byte(4*w+2), rb_byte(4*w+1), rb_byte(4*w)}));
        end
    endtask

    task automatic do_commit(input logic rel, input logic cmt, input string tag);
        @(negedge clk); commit = cmt; release_req = rel;
        @(negedge clk); commit = 0; release_req = 0;
        model_commit(rel);
        check_state(tag);
        @(negedge clk);
        m_fault = 0; m_clr = 0;
        check_state({tag, " after-pulse"});
        check_readback(tag);
    endtask

    task automatic base_image();
        for (int i = 0; i < 64; i++) img[i] = 0;
        img[0] = 1;
        for (int t = 0; t < NT; t++) begin
            img[48+t] = 8'(t + 1);
            img[16+2*t] = 8'(8 * (t + 1));
        end
    endtask

    task automatic rand_image();
        int k;
        for (int i = 0; i < 64; i++) img[i] = 0;
        k = $urandom % 8;
        img[0] = (k == 0) ? 8'd0 : (k == 1) ? 8'(2 + $urandom % 250) : 8'd1;
        for (int t = 0; t < NT; t++) begin
            img[48+t] = 8'($urandom % 19);
            img[16+2*t] = 8'($urandom % 68);
            if ($urandom % 16 == 0) img[17+2*t] = 8'(1 + $urandom % 3);
        end
        if ($urandom % 5 == 0) begin
            k = $urandom % 3;
            if (k == 0) img[1 + $urandom % 15] = 8'(1 + $urandom % 255);
            else if (k == 1) img[32 + $urandom % 16] = 8'(1 + $urandom % 255);
            else img[56 + $urandom % 8] = 8'(1 + $urandom % 255);
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        for (int i = 0; i < 64; i++) img[i] = 0;
        model_init(); m_fault = 0; m_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("R1 reset");
        check_readback("R1 reset");

        base_image(); write_image();
        do_commit(0, 1, "R2 R3 load");

        base_image(); img[48] = 16; img[16] = 64; img[55] = 16; img[30] = 64; write_image();
        do_commit(0, 1, "R6 limits valid");

        img[49] = 17; write_image();
        do_commit(0, 1, "R6 rows 17");
        img[49] = 2; img[18] = 65; write_image();
        do_commit(0, 1, "R6 colbytes 65");
        img[18] = 0; img[19] = 1; write_image();
        do_commit(0, 1, "R6 colbytes high byte");

        base_image(); img[0] = 2; write_image();
        do_commit(0, 1, "R5 selector 2");

        base_image(); img[5] = 8'h40; write_image();
        do_commit(0, 1, "R7 reserved byte 5");
        img[5] = 0; img[63] = 8'h01; write_image();
        do_commit(0, 1, "R7 reserved byte 63");

        base_image(); img[0] = 0; img[40] = 8'hff; img[48] = 8'hff; write_image();
        do_commit(0, 1, "R4 R9 selector 0");

        base_image(); write_image();
        do_commit(0, 1, "R2 reload");
        do_commit(1, 0, "R8 R9 release");
        do_commit(0, 1, "R10 recommit staged");
        do_commit(1, 1, "R8 release beats commit");

        // R10: a write in the commit cycle is not seen by that commit.
        @(negedge clk); commit = 1; wr_en = 1; wr_addr = 0; wr_data = 32'h0000_0003;
        @(negedge clk); commit = 0; wr_en = 0;
        model_commit(0);
        img[0] = 3; img[1] = 0; img[2] = 0; img[3] = 0;
        check_state("R10 same-cycle write");
        @(negedge clk); m_fault = 0; m_clr = 0;
        do_commit(0, 1, "R10 new staging seen");

        for (int n = 0; n < 60; n++) begin
            rand_image(); write_image();
            do_commit(($urandom % 10) == 0, 1, "R5 R6 R7 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule